// File: doc/BRIEF.md
# Processor Sleep Clock Gate

This block stops the processor core clock to put the core into a light sleep, and turns the clock back on when an interrupt arrives. The core raises a one-cycle sleep request when it executes a wait-for-interrupt or wait-for-event instruction. The block acts on the request only while the low-power select input is 0. It then holds the clock running until the core reports that the instruction in flight has retired, and only after that does it stop the clock.

A sleeping core wakes when any interrupt line is both pending and enabled, on either the normal or the fast group. No software action is needed for this. A second clock output is a straight copy of the master clock and never stops. It keeps interrupt sampling and trace logic alive, and it lets other bus masters keep moving data while the core is asleep. Reset always leaves the core clock running.

The gate itself latches its enable while the master clock is low. Because of this, every core clock pulse is either a full master-clock high phase or absent.

Top module: `core_sleep_gate`

## Requirements
- R1: While reset is asserted and after it is released, `sleeping` is 0 and `core_clk` follows `mck`.
- R2: `free_clk` equals `mck` at all times, including during sleep and reset.
- R3: A sleep request taken while `lp_sel` is 1 is ignored: `sleeping` stays 0 and the core clock keeps running.
- R4: A sleep request taken while `lp_sel` is 0 and no enabled interrupt is pending does not stop the clock by itself. `sleeping` rises on the edge that samples `instr_done` high, and not before.
- R5: While sleeping, a normal interrupt line that is pending with its enable bit set clears `sleeping` on the next `mck` rising edge.
- R6: While sleeping, a fast interrupt line that is pending with its enable bit set clears `sleeping` on the next `mck` rising edge.
- R7: If an enabled interrupt is already pending in the cycle the sleep request is taken, the core clock is never stopped.
- R8: A pending interrupt whose enable bit is 0, in either group, does not wake the core.
- R9: `core_clk` high phases are suppressed exactly for the `mck` periods that start after `sleeping` has been sampled high on a falling edge. No partial pulse is produced.
- R10: An enabled pending interrupt that arrives while the block waits for `instr_done` cancels the sleep, and the clock is never stopped.
- R11: `instr_done` has no effect unless a sleep request is waiting for it.
- R12: Asserting `rst_n` during sleep clears `sleeping` at once and restores the core clock from the next high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mck | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle pulse from a wait-for-interrupt or wait-for-event instruction |
| instr_done | input | 1 | Core reports that the instruction in flight has retired |
| lp_sel | input | 1 | Low-power select; 1 makes the block ignore sleep requests |
| norm_pend | input | NORM_W | Pending normal interrupt lines |
| norm_en | input | NORM_W | Enable bits of normal interrupt lines |
| fast_pend | input | FAST_W | Pending fast interrupt lines |
| fast_en | input | FAST_W | Enable bits of fast interrupt lines |
| core_clk | output | 1 | Gated processor core clock |
| free_clk | output | 1 | Ungated copy of the master clock |
| sleeping | output | 1 | 1 while the core clock is stopped |

## Verification
The hardest cases to reach are the two races around entry. In one, an interrupt arrives while the request is still waiting for the instruction to retire. In the other, an interrupt is already pending in the same cycle as the request. Both need the request, the enable and the pending inputs aligned to a single cycle. The stimulus table sets up each race exactly in consecutive rows, and every row carries the expected status. The gated clock is sampled in the middle of each high phase and compared with the status seen on the falling edge before it. A reset driven mid-sleep between two edges covers the asynchronous exit.

// File: rtl/core_sleep_pkg.sv
package core_sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_WAIT_DONE = 2'd1,
    ST_SLEEP     = 2'd2
  } slp_state_e;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
  parameter int NORM_W = 8,
  parameter int FAST_W = 2
) (
  input  logic [NORM_W-1:0] norm_pend,
  input  logic [NORM_W-1:0] norm_en,
  input  logic [FAST_W-1:0] fast_pend,
  input  logic [FAST_W-1:0] fast_en,
  output logic              wake
);
  logic [NORM_W-1:0] norm_hit;
  logic [FAST_W-1:0] fast_hit;

  for (genvar i = 0; i < NORM_W; i++) begin : g_norm
    assign norm_hit[i] = norm_pend[i] & norm_en[i];
  end
  for (genvar j = 0; j < FAST_W; j++) begin : g_fast
    assign fast_hit[j] = fast_pend[j] & fast_en[j];
  end

  assign wake = (|norm_hit) | (|fast_hit);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import core_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic instr_done,
  input  logic lp_sel,
  input  logic wake,
  output logic gate_en,
  output logic sleeping
);
  slp_state_e state_q, state_d;
  logic       take_req;

  assign take_req = sleep_req & ~lp_sel;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (take_req && !wake) state_d = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (wake)            state_d = ST_RUN;
        else if (instr_done) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign sleeping = (state_q == ST_SLEEP);
  assign gate_en  = ~sleeping;

  assert_lpsel_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && lp_sel) |=> (state_q == ST_RUN));

  assert_sleep_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SLEEP) |-> $past(state_q == ST_WAIT_DONE && instr_done));

  assert_wake_exits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wake) |=> (state_q == ST_RUN));

  assert_pending_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wake) |=> (state_q == ST_RUN));

  assert_wait_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_DONE && wake) |=> (state_q == ST_RUN));

  assert_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && instr_done && !sleep_req) |=> (state_q == ST_RUN));
endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/core_sleep_gate.sv
module core_sleep_gate #(
  parameter int NORM_W      = 8,
  parameter int FAST_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mck,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              instr_done,
  input  logic              lp_sel,
  input  logic [NORM_W-1:0] norm_pend,
  input  logic [NORM_W-1:0] norm_en,
  input  logic [FAST_W-1:0] fast_pend,
  input  logic [FAST_W-1:0] fast_en,
  output logic              core_clk,
  output logic              free_clk,
  output logic              sleeping
);
  logic srst_n;
  logic wake;
  logic gate_en;

  slp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (mck),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  slp_wake_detect #(.NORM_W(NORM_W), .FAST_W(FAST_W)) u_wake (
    .norm_pend (norm_pend),
    .norm_en   (norm_en),
    .fast_pend (fast_pend),
    .fast_en   (fast_en),
    .wake      (wake)
  );

  slp_fsm u_fsm (
    .clk        (mck),
    .rst_n      (srst_n),
    .sleep_req  (sleep_req),
    .instr_done (instr_done),
    .lp_sel     (lp_sel),
    .wake       (wake),
    .gate_en    (gate_en),
    .sleeping   (sleeping)
  );

  slp_clk_gate u_gate (
    .clk  (mck),
    .en   (gate_en),
    .gclk (core_clk)
  );

  assign free_clk = mck;

  assert_reset_runs_R12: assert property (@(posedge mck) !srst_n |-> !sleeping);
endmodule

// File: tb/core_sleep_gate_bench.sv
`timescale 1ns/1ps
module core_sleep_gate_bench;
  localparam int NW = 4;
  localparam int FW = 2;
  localparam int ROWS = 21;

  logic          mck = 1'b0;
  logic          rst_n;
  logic          sleep_req, instr_done, lp_sel;
  logic [NW-1:0] norm_pend, norm_en;
  logic [FW-1:0] fast_pend, fast_en;
  logic          core_clk, free_clk, sleeping;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  always #5 mck = ~mck;

  core_sleep_gate #(.NORM_W(NW), .FAST_W(FW), .SYNC_STAGES(2)) u_core_sleep_gate (
    .mck(mck), .rst_n(rst_n), .sleep_req(sleep_req), .instr_done(instr_done),
    .lp_sel(lp_sel), .norm_pend(norm_pend), .norm_en(norm_en),
    .fast_pend(fast_pend), .fast_en(fast_en),
    .core_clk(core_clk), .free_clk(free_clk), .sleeping(sleeping)
  );

  // row: [15] req [14] done [13] lp_sel [12:9] npend [8:5] nen [4:3] fpend [2:1] fen [0] expected sleeping
  localparam logic [15:0] TBL [0:ROWS-1] = '{
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 0  idle R1
    {3'b101, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 1  request with lp_sel=1, R3
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 2  R3
    {3'b010, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 3  stray done, R11
    {3'b100, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 4  request, waiting, R4
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 5  still waiting, R4
    {3'b010, 4'h0, 4'h0, 2'b00, 2'b00, 1'b1},  // 6  done -> sleep, R4
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b1},  // 7  asleep, R9
    {3'b000, 4'hF, 4'h0, 2'b00, 2'b00, 1'b1},  // 8  normal pending not enabled, R8
    {3'b000, 4'h0, 4'hF, 2'b11, 2'b00, 1'b1},  // 9  fast pending not enabled, R8
    {3'b000, 4'h2, 4'h2, 2'b00, 2'b00, 1'b0},  // 10 normal wake, R5
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 11 clock back, R9
    {3'b100, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 12 request, R4
    {3'b010, 4'h0, 4'h0, 2'b00, 2'b00, 1'b1},  // 13 sleep
    {3'b000, 4'h0, 4'h0, 2'b01, 2'b01, 1'b0},  // 14 fast wake, R6
    {3'b100, 4'h8, 4'h8, 2'b00, 2'b00, 1'b0},  // 15 request with pending, R7
    {3'b010, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 16 done after abort, R7 R11
    {3'b100, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 17 request, waiting
    {3'b000, 4'h0, 4'h0, 2'b10, 2'b10, 1'b0},  // 18 wake while waiting, R10
    {3'b010, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0},  // 19 done ignored, R10 R11
    {3'b000, 4'h0, 4'h0, 2'b00, 2'b00, 1'b0}   // 20 idle
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [15:0] r);
    sleep_req  = r[15];
    instr_done = r[14];
    lp_sel     = r[13];
    norm_pend  = r[12:9];
    norm_en    = r[8:5];
    fast_pend  = r[4:3];
    fast_en    = r[2:1];
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev_exp;
    rst_n = 1'b0;
    drive(16'h0000);
    // R1 reset state
    @(negedge mck);
    chk("R1 sleeping in reset", sleeping, 1'b0);
    @(posedge mck); #2;
    chk("R1 core_clk high in reset", core_clk, 1'b1);
    chk("R2 free_clk high", free_clk, 1'b1);
    @(negedge mck); #2;
    chk("R2 free_clk low", free_clk, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge mck);
    chk("R1 sleeping after release", sleeping, 1'b0);

    prev_exp = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      drive(TBL[i]);
      @(posedge mck); #2;
      chk($sformatf("R9 core_clk row %0d", i), core_clk, ~prev_exp);
      chk($sformatf("R2 free_clk row %0d", i), free_clk, 1'b1);
      @(negedge mck);
      chk($sformatf("R3-8/R10/R11 sleeping row %0d", i), sleeping, TBL[i][0]);
      prev_exp = TBL[i][0];
    end

    // R12: reset while asleep
    drive(16'h8000);            // request
    @(negedge mck);
    drive(16'h4000);            // done
    @(negedge mck);
    drive(16'h0000);
    chk("R12 entered sleep", sleeping, 1'b1);
    @(posedge mck); #2;
    chk("R9 core_clk stopped before reset", core_clk, 1'b0);
    chk("R2 free_clk during sleep", free_clk, 1'b1);
    @(negedge mck); #1;
    rst_n = 1'b0;
    #1;
    chk("R12 sleeping cleared by reset", sleeping, 1'b0);
    @(posedge mck); #2;
    chk("R12 core_clk restored", core_clk, 1'b1);
    @(negedge mck);
    rst_n = 1'b1;
    repeat (3) @(negedge mck);
    chk("R12 running after release", sleeping, 1'b0);
    @(posedge mck); #2;
    chk("R1 core_clk after release", core_clk, 1'b1);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule